// File: doc/BRIEF.md
# Bidirectional Synchronization Trigger Controller

This block owns one external synchronization pin. A configuration bit sets the pin's direction. With the bit clear, the pin is a trigger input. A rising edge on it makes the block assert a hold command to the sample-and-hold stage. On the following clock edge, the block issues a one-cycle start strobe. The strobe goes either to the converter or to the limit comparator, depending on the operation the current instruction requests.

With the bit set, the pin becomes a busy indicator. An internal run request starts the same hold-then-start sequence. The pin is driven high from the start of the operation until the done input reports completion.

The pin input is resynchronised before edge detection. While an operation is in flight, the controller accepts no further trigger. The analog front end and the converter sit outside the block. They are reached only through the hold, start and done signals.

Top module: `sync_trig_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the pin output enable, pin output, hold command and both start strobes are all 0, so the pin comes up as an input.
- R2: The pin output enable takes the value of the direction bit (1 = output) on the clock edge after that value is sampled.
- R3: In input mode (direction bit 0), the pin passes through SYNC_STAGES flops (default 2). A 0-to-1 change, first sampled at clock edge k, raises the hold command at edge k+SYNC_STAGES and not earlier.
- R4: One clock edge after the hold command rises, exactly one start strobe pulses for one cycle. convStart pulses when the operation select is 0 (conversion) at that edge; cmpStart pulses when it is 1 (limit comparison). The two never pulse together.
- R5: Once raised, the hold command stays high until the clock edge at which opDone is sampled high after the start strobe's edge. It falls on that edge.
- R6: A rising edge on the pin while the hold command is high is discarded. A pin level that stays high after completion does not start a new operation.
- R7: In output mode, edges on the pin have no effect. A runReq sampled high while idle raises the hold command on that same edge.
- R8: In output mode, the pin output goes high on the edge that issues the start strobe and goes low on the edge that ends the operation. It is 0 at all other times, and always 0 in input mode.
- R9: opDone sampled during the hold step, before the start strobe's edge, is ignored. The start strobe still follows and the hold command stays high.
- R10: A falling edge on the pin does not start an operation. In input mode, runReq is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPinIsOut | input | 1 | Pin direction: 0 input trigger, 1 busy output |
| reqCompare | input | 1 | Requested operation: 0 conversion, 1 limit comparison |
| runReq | input | 1 | Internal start request, used in output mode |
| opDone | input | 1 | Converter/comparator completion pulse |
| syncPinIn | input | 1 | Pin level seen from the pad |
| syncPinOut | output | 1 | Level driven onto the pin in output mode |
| syncPinOe | output | 1 | Pin output enable |
| holdCmd | output | 1 | Hold command to the sample-and-hold |
| convStart | output | 1 | One-cycle conversion start strobe |
| cmpStart | output | 1 | One-cycle limit-comparison start strobe |

## Verification
The assertions assume the direction bit and the operation select stay constant from trigger until completion. They also assume that opDone arrives only while an operation is pending. The stimulus changes the direction bit only between operations, with the pin low and the controller idle. It holds reqCompare steady over every launch edge, and it raises opDone either after the start strobe or, on purpose, during the hold step.

// File: rtl/sync_trig_pkg.sv
package sync_trig_pkg;

  // Controller phases: waiting, holding before launch, operation running
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } trigState_t;

  // Strobes sent from control to datapath, each valid for one cycle
  typedef struct packed {
    logic capture;  // accept a trigger, assert hold
    logic launch;   // issue the start strobe
    logic finish;   // operation complete, release everything
  } ctlStrobe_t;

endpackage

// File: rtl/sync_trig_dp.sv
module sync_trig_dp
  import sync_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncPinIn,
  input  logic       cfgPinIsOut,
  input  logic       reqCompare,
  input  ctlStrobe_t strobe,
  output logic       pinRise,
  output logic       syncPinOut,
  output logic       syncPinOe,
  output logic       holdCmd,
  output logic       convStart,
  output logic       cmpStart
);

  localparam int CHAIN_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
  localparam int CHAIN_MSB = CHAIN_W - 1;

  logic [CHAIN_W-1:0] syncChain;
  logic               lastSeen;

  // Metastability chain: bit 0 samples the pad, the top bit is trusted
  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_W; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= syncPinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  // Level memory keeps tracking in every state so a held-high pin never re-fires
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastSeen <= 1'b0;
    else       lastSeen <= syncChain[CHAIN_MSB];
  end

  assign pinRise = syncChain[CHAIN_MSB] & ~lastSeen;

  // Direction follows the configuration bit, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPinOe <= 1'b0;
    else       syncPinOe <= cfgPinIsOut;
  end

  // Hold command: set on capture, cleared on finish
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCmd <= 1'b0;
    else if (strobe.finish)  holdCmd <= 1'b0;
    else if (strobe.capture) holdCmd <= 1'b1;
  end

  // Start strobes, routed by the requested operation at the launch edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      cmpStart  <= 1'b0;
    end else begin
      convStart <= strobe.launch & ~reqCompare;
      cmpStart  <= strobe.launch &  reqCompare;
    end
  end

  // Busy level on the pin, only in output mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              syncPinOut <= 1'b0;
    else if (strobe.finish) syncPinOut <= 1'b0;
    else if (strobe.launch) syncPinOut <= cfgPinIsOut;
  end

endmodule

// File: rtl/sync_trig_ctrl.sv
module sync_trig_ctrl
  import sync_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgPinIsOut,
  input  logic       pinRise,
  input  logic       runReq,
  input  logic       opDone,
  output ctlStrobe_t strobe
);

  trigState_t state;
  trigState_t stateNext;
  logic       trigger;

  // Trigger source depends on pin direction
  assign trigger = cfgPinIsOut ? runReq : pinRise;

  always_comb begin
    strobe         = '0;
    stateNext      = state;
    unique case (state)
      ST_IDLE: begin
        if (trigger) begin
          strobe.capture = 1'b1;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        strobe.launch = 1'b1;
        stateNext     = ST_RUN;
      end
      ST_RUN: begin
        if (opDone) begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sync_trig_ctl.sv
module sync_trig_ctl
  import sync_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgPinIsOut,
  input  logic reqCompare,
  input  logic runReq,
  input  logic opDone,
  input  logic syncPinIn,
  output logic syncPinOut,
  output logic syncPinOe,
  output logic holdCmd,
  output logic convStart,
  output logic cmpStart
);

  ctlStrobe_t strobe;
  logic       pinRise;

  sync_trig_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgPinIsOut (cfgPinIsOut),
    .pinRise     (pinRise),
    .runReq      (runReq),
    .opDone      (opDone),
    .strobe      (strobe)
  );

  sync_trig_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .syncPinIn   (syncPinIn),
    .cfgPinIsOut (cfgPinIsOut),
    .reqCompare  (reqCompare),
    .strobe      (strobe),
    .pinRise     (pinRise),
    .syncPinOut  (syncPinOut),
    .syncPinOe   (syncPinOe),
    .holdCmd     (holdCmd),
    .convStart   (convStart),
    .cmpStart    (cmpStart)
  );

endmodule

// File: rtl/sync_trig_chk.sv
module sync_trig_chk (
  input logic clk,
  input logic rstN,
  input logic cfgPinIsOut,
  input logic opDone,
  input logic syncPinOut,
  input logic syncPinOe,
  input logic holdCmd,
  input logic convStart,
  input logic cmpStart
);

  AST_OE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (syncPinOe == $past(cfgPinIsOut))); // R2

  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(convStart && cmpStart)); // R4

  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (convStart || cmpStart) |=> !(convStart || cmpStart)); // R4

  AST_HOLD_THEN_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdCmd) |=> (convStart || cmpStart)); // R4

  AST_START_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (convStart || cmpStart) |-> holdCmd); // R5

  AST_HOLD_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdCmd) |-> $past(opDone)); // R5

  AST_BUSY_PIN_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    syncPinOut |-> holdCmd); // R8

  AST_BUSY_PIN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    syncPinOut |-> syncPinOe); // R8

endmodule

bind sync_trig_ctl sync_trig_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgPinIsOut (cfgPinIsOut),
  .opDone      (opDone),
  .syncPinOut  (syncPinOut),
  .syncPinOe   (syncPinOe),
  .holdCmd     (holdCmd),
  .convStart   (convStart),
  .cmpStart    (cmpStart)
);

// File: tb/test_sync_trig_ctl.sv
`timescale 1ns/1ps
module test_sync_trig_ctl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPinIsOut = 1'b0;
  logic reqCompare = 1'b0;
  logic runReq = 1'b0;
  logic opDone = 1'b0;
  logic syncPinIn = 1'b0;
  logic syncPinOut, syncPinOe, holdCmd, convStart, cmpStart;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  sync_trig_ctl i_sync_trig_ctl (
    .clk(clk), .rstN(rstN), .cfgPinIsOut(cfgPinIsOut), .reqCompare(reqCompare),
    .runReq(runReq), .opDone(opDone), .syncPinIn(syncPinIn),
    .syncPinOut(syncPinOut), .syncPinOe(syncPinOe), .holdCmd(holdCmd),
    .convStart(convStart), .cmpStart(cmpStart)
  );

  // Vector fields: {outMode, compare, waitCycles[3:0]}
  localparam logic [5:0] VEC [8] = '{
    {1'b0, 1'b0, 4'd0}, {1'b0, 1'b1, 4'd2}, {1'b1, 1'b0, 4'd1}, {1'b1, 1'b1, 4'd0},
    {1'b0, 1'b1, 4'd5}, {1'b1, 1'b0, 4'd3}, {1'b0, 1'b0, 4'd7}, {1'b1, 1'b1, 4'd4}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Full operation in the chosen mode
  task automatic runOp(input logic isOut, input logic isCmp, input int waitCycles);
    cfgPinIsOut = isOut;
    reqCompare  = isCmp;
    tick();
    chk("R2", "oe", syncPinOe, isOut);
    if (!isOut) begin
      syncPinIn = 1'b1;
      tick(); tick();
      chk("R3", "hold early", holdCmd, 0);
      tick();
      chk("R3", "hold raised", holdCmd, 1);
    end else begin
      runReq = 1'b1;
      tick();
      runReq = 1'b0;
      chk("R7", "hold on runReq", holdCmd, 1);
    end
    chk("R4", "no start yet", convStart | cmpStart, 0);
    tick();
    chk("R4", "convStart", convStart, !isCmp);
    chk("R4", "cmpStart", cmpStart, isCmp);
    chk("R8", "busy pin", syncPinOut, isOut);
    tick();
    chk("R4", "strobe width", convStart | cmpStart, 0);
    for (int w = 0; w < waitCycles; w++) begin
      chk("R5", "hold kept", holdCmd, 1);
      tick();
    end
    opDone = 1'b1;
    tick();
    opDone = 1'b0;
    chk("R5", "hold released", holdCmd, 0);
    chk("R8", "busy pin low", syncPinOut, 0);
    if (!isOut) begin
      tick(); tick(); tick();
      chk("R6", "held level no retrigger", holdCmd, 0);
      syncPinIn = 1'b0;
      tick(); tick(); tick();
      chk("R10", "falling edge no trigger", holdCmd, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk("R1", "oe in reset", syncPinOe, 0);
    chk("R1", "hold in reset", holdCmd, 0);
    tick();
    rstN = 1'b1;
    tick();
    chk("R1", "oe after reset", syncPinOe, 0);
    chk("R1", "pin out", syncPinOut, 0);
    chk("R1", "starts", convStart | cmpStart, 0);
    chk("R1", "hold", holdCmd, 0);

    // R2: one-edge delay of output enable
    cfgPinIsOut = 1'b1;
    #0.5;
    chk("R2", "oe before edge", syncPinOe, 0);
    tick();
    chk("R2", "oe after edge", syncPinOe, 1);
    cfgPinIsOut = 1'b0;
    tick();
    chk("R2", "oe back to input", syncPinOe, 0);

    // Vector walk
    for (int v = 0; v < 8; v++) begin
      runOp(VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
    end

    // R6: new edge while running is discarded
    cfgPinIsOut = 1'b0; reqCompare = 1'b0;
    tick();
    syncPinIn = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R6", "conv started", holdCmd, 1);
    syncPinIn = 1'b0;
    tick(); tick(); tick();
    syncPinIn = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R6", "no second start", convStart | cmpStart, 0);
    opDone = 1'b1; tick(); opDone = 1'b0;
    chk("R6", "released", holdCmd, 0);
    tick(); tick(); tick();
    chk("R6", "edge during run lost", holdCmd, 0);
    syncPinIn = 1'b0;
    tick(); tick(); tick();

    // R7: pin edges ignored in output mode
    cfgPinIsOut = 1'b1;
    tick();
    syncPinIn = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R7", "pin edge ignored", holdCmd, 0);
    chk("R8", "pin out idle", syncPinOut, 0);
    syncPinIn = 1'b0;
    tick(); tick(); tick();
    cfgPinIsOut = 1'b0;
    tick();

    // R10: runReq ignored in input mode
    runReq = 1'b1;
    tick(); tick();
    runReq = 1'b0;
    chk("R10", "runReq ignored", holdCmd, 0);

    // R9: done during hold step ignored
    reqCompare = 1'b1;
    syncPinIn = 1'b1;
    tick(); tick(); tick();
    chk("R9", "hold step", holdCmd, 1);
    opDone = 1'b1;
    tick();
    opDone = 1'b0;
    chk("R9", "start despite done", cmpStart, 1);
    chk("R9", "hold kept", holdCmd, 1);
    chk("R8", "no busy in input mode", syncPinOut, 0);
    tick();
    chk("R9", "still holding", holdCmd, 1);
    opDone = 1'b1; tick(); opDone = 1'b0;
    chk("R9", "released later", holdCmd, 0);
    syncPinIn = 1'b0;
    tick(); tick(); tick();

    finishRun();
  end

endmodule